// File: doc/BRIEF.md
# Machine Cycle Bus Strobe Generator

This block turns one request for a processor machine cycle into the timed active-low bus strobes for that cycle. It also drives the address and write-data buses and captures read data. Seven cycle kinds are supported: opcode fetch, memory read, memory write, I/O read, I/O write, interrupt acknowledge and dynamic-memory refresh. A request carries a cycle kind, an address and a write byte. Every cycle lasts three T-states. Each T-state is two clocks long, a first half (A) and a second half (B), so that a strobe can start in the middle of a T-state. Every cycle therefore takes six clocks.

The receiver decodes the kind of cycle from the strobes that are low together. The first-cycle strobe with the memory strobe marks a fetch. The first-cycle strobe with the I/O strobe marks an interrupt acknowledge. The refresh strobe with the memory strobe marks a refresh. During a refresh the low byte of the address comes from an internal 8-bit counter, and the upper bits come from the request. A tri-state enable output is high whenever the releasable strobes and the address are driven.

The sequencer has the states IDLE, T1A, T1B, T2A, T2B, T3A and T3B. It makes these transitions:
- IDLE goes to T1A when it accepts a request.
- Each state then steps to the next one on each clock.
- T3B goes to T1A if a new request is accepted, and otherwise to IDLE.

Top module: `mcyc_strobe_gen`

## Requirements
- R1: After reset every strobe is high, `tri_oe`, `bus_doe`, `rd_valid` are low, `req_ready` is high and the refresh counter is 0.
- R2: A request is accepted on a clock where `req_valid` and `req_ready` are high and `req_type` is 0 to 6. `req_ready` is high only in IDLE and T3B, and a cycle lasts exactly six clocks (T1A..T3B).
- R3: Type 0 (opcode fetch) drives `m1_n`, `mreq_n` and `rd_n` low.
- R4: Type 5 (interrupt acknowledge) drives `m1_n` and `iorq_n` low, keeps `rd_n` high, and still captures `bus_din` as the response byte.
- R5: Type 6 (refresh) drives `rfsh_n` and `mreq_n` low, keeps `m1_n`, `rd_n` and `wr_n` high, and puts the refresh counter on address bits 7..0 with the requested upper bits.
- R6: Types 1 to 4 drive these strobes: 1 memory read (`mreq_n`, `rd_n`), 2 memory write (`mreq_n`, `wr_n`), 3 I/O read (`iorq_n`, `rd_n`), 4 I/O write (`iorq_n`, `wr_n`). `mreq_n` and `iorq_n` are never low together.
- R7: `m1_n` and `rfsh_n` are low from T1A through T3B. `mreq_n`, `iorq_n` and `rd_n` are low from T1B through T3B. The request address is on `bus_addr` for all six clocks.
- R8: For write types, `wr_n` and `bus_doe` are low/high from T2A through T3B, and `bus_dout` holds the request write byte.
- R9: For types 0, 1, 3 and 5, `bus_din` is sampled at the clock edge that ends T3A. `rd_data` then holds it, and `rd_valid` is high for exactly the T3B clock.
- R10: The refresh counter advances by one at the end of each refresh cycle and wraps from 255 to 0.
- R11: `tri_oe` is high in T1A..T3B and low in IDLE.
- R12: A request with `req_type` 7 starts no cycle: strobes stay high and `tri_oe` stays low.
- R13: A request accepted in T3B starts T1A on the very next clock with no idle clock between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Cycle request present |
| req_type | input | 3 | Cycle kind, 0..6; 7 means none |
| req_addr | input | AW | Cycle address |
| req_wdata | input | DW | Write byte |
| req_ready | output | 1 | Request can be taken this clock |
| bus_addr | output | AW | Address bus |
| bus_dout | output | DW | Write data bus |
| bus_doe | output | 1 | Write data bus drive enable |
| bus_din | input | DW | Read data bus |
| tri_oe | output | 1 | Enable for the releasable strobes and address |
| m1_n | output | 1 | First-cycle strobe |
| mreq_n | output | 1 | Memory strobe |
| iorq_n | output | 1 | I/O strobe |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |
| rfsh_n | output | 1 | Refresh strobe |
| rd_data | output | DW | Captured read byte |
| rd_valid | output | 1 | Captured read byte is new |

## Verification
The accepting edge puts the sequencer in T1A, so phase p of a cycle (0 = T1A .. 5 = T3B) is seen in the half period after the (p+1)-th rising edge from acceptance. The bench samples every strobe at each of those six falling edges and compares it with a table computed from the cycle kind and the phase. It presents the read byte on `bus_din` only during T3A, so a capture on any other edge yields the wrong value. It expects `rd_data`/`rd_valid` in T3B and expects the refresh counter value one whole cycle after the previous refresh.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
    typedef enum logic [2:0] {
        CY_FETCH = 3'd0,
        CY_MRD   = 3'd1,
        CY_MWR   = 3'd2,
        CY_IORD  = 3'd3,
        CY_IOWR  = 3'd4,
        CY_INTA  = 3'd5,
        CY_RFSH  = 3'd6,
        CY_NONE  = 3'd7
    } cyc_type_e;

    typedef enum logic [2:0] {
        TS_IDLE = 3'd0,
        TS_T1A  = 3'd1,
        TS_T1B  = 3'd2,
        TS_T2A  = 3'd3,
        TS_T2B  = 3'd4,
        TS_T3A  = 3'd5,
        TS_T3B  = 3'd6
    } tstate_e;

    typedef struct packed {
        logic m1_n;
        logic mreq_n;
        logic iorq_n;
        logic rd_n;
        logic wr_n;
        logic rfsh_n;
    } strobes_t;

    localparam strobes_t STROBES_IDLE = '{m1_n: 1'b1, mreq_n: 1'b1, iorq_n: 1'b1,
                                          rd_n: 1'b1, wr_n: 1'b1, rfsh_n: 1'b1};

    function automatic logic is_read_kind(cyc_type_e t);
        return (t == CY_FETCH) || (t == CY_MRD) || (t == CY_IORD) || (t == CY_INTA);
    endfunction

    function automatic logic is_write_kind(cyc_type_e t);
        return (t == CY_MWR) || (t == CY_IOWR);
    endfunction
endpackage

// File: rtl/mcyc_tseq.sv
module mcyc_tseq
    import mcyc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  cyc_type_e req_type,
    output tstate_e   state,
    output logic      ready,
    output logic      accept
);
    tstate_e state_q;
    tstate_e state_d;

    assign ready  = (state_q == TS_IDLE) || (state_q == TS_T3B);
    assign accept = ready && req_valid && (req_type != CY_NONE);
    assign state  = state_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_IDLE: state_d = accept ? TS_T1A : TS_IDLE;
            TS_T1A:  state_d = TS_T1B;
            TS_T1B:  state_d = TS_T2A;
            TS_T2A:  state_d = TS_T2B;
            TS_T2B:  state_d = TS_T3A;
            TS_T3A:  state_d = TS_T3B;
            TS_T3B:  state_d = accept ? TS_T1A : TS_IDLE;
            default: state_d = TS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TS_IDLE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/mcyc_strobe_dec.sv
module mcyc_strobe_dec
    import mcyc_pkg::*;
(
    input  tstate_e   state,
    input  cyc_type_e kind,
    output strobes_t  strobes,
    output logic      data_oe,
    output logic      tri_oe,
    output logic      capture
);
    logic in_cycle;
    logic mid_on;
    logic wr_on;

    always_comb begin
        in_cycle = 1'b0;
        mid_on   = 1'b0;
        wr_on    = 1'b0;
        unique case (state)
            TS_IDLE: begin end
            TS_T1A:  in_cycle = 1'b1;
            TS_T1B:  begin in_cycle = 1'b1; mid_on = 1'b1; end
            TS_T2A, TS_T2B, TS_T3A, TS_T3B: begin
                in_cycle = 1'b1; mid_on = 1'b1; wr_on = 1'b1;
            end
            default: begin end
        endcase
    end

    always_comb begin
        strobes = STROBES_IDLE;
        data_oe = 1'b0;
        tri_oe  = in_cycle;
        capture = (state == TS_T3A) && is_read_kind(kind);
        if (in_cycle) begin
            unique case (kind)
                CY_FETCH: begin
                    strobes.m1_n   = 1'b0;
                    strobes.mreq_n = !mid_on;
                    strobes.rd_n   = !mid_on;
                end
                CY_MRD: begin
                    strobes.mreq_n = !mid_on;
                    strobes.rd_n   = !mid_on;
                end
                CY_MWR: begin
                    strobes.mreq_n = !mid_on;
                    strobes.wr_n   = !wr_on;
                    data_oe        = wr_on;
                end
                CY_IORD: begin
                    strobes.iorq_n = !mid_on;
                    strobes.rd_n   = !mid_on;
                end
                CY_IOWR: begin
                    strobes.iorq_n = !mid_on;
                    strobes.wr_n   = !wr_on;
                    data_oe        = wr_on;
                end
                CY_INTA: begin
                    strobes.m1_n   = 1'b0;
                    strobes.iorq_n = !mid_on;
                end
                CY_RFSH: begin
                    strobes.rfsh_n = 1'b0;
                    strobes.mreq_n = !mid_on;
                end
                default: begin end
            endcase
        end
    end
endmodule

// File: rtl/mcyc_rfsh_ctr.sv
module mcyc_rfsh_ctr #(
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [RW-1:0] count
);
    localparam logic [RW-1:0] ONE = RW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    count <= '0;
        else if (step) count <= count + ONE;
    end
endmodule

// File: rtl/mcyc_strobe_gen.sv
module mcyc_strobe_gen
    import mcyc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_type,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_dout,
    output logic          bus_doe,
    input  logic [DW-1:0] bus_din,
    output logic          tri_oe,
    output logic          m1_n,
    output logic          mreq_n,
    output logic          iorq_n,
    output logic          rd_n,
    output logic          wr_n,
    output logic          rfsh_n,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    localparam int UPW = (AW > RW) ? AW - RW : 1;

    tstate_e       state;
    logic          accept;
    cyc_type_e     kind_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [RW-1:0] rcount;
    strobes_t      strobes;
    logic          capture;
    logic          rfsh_step;

    mcyc_tseq u_tseq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_type  (cyc_type_e'(req_type)),
        .state     (state),
        .ready     (req_ready),
        .accept    (accept)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= CY_NONE;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            kind_q  <= cyc_type_e'(req_type);
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    mcyc_strobe_dec u_dec (
        .state   (state),
        .kind    (kind_q),
        .strobes (strobes),
        .data_oe (bus_doe),
        .tri_oe  (tri_oe),
        .capture (capture)
    );

    assign rfsh_step = (state == TS_T3B) && (kind_q == CY_RFSH);

    mcyc_rfsh_ctr #(.RW(RW)) u_rctr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (rfsh_step),
        .count (rcount)
    );

    generate
        if (AW > RW) begin : g_split
            logic [UPW-1:0] upper;
            assign upper    = addr_q[AW-1:RW];
            assign bus_addr = (kind_q == CY_RFSH) ? {upper, rcount} : addr_q;
        end else begin : g_whole
            assign bus_addr = (kind_q == CY_RFSH) ? rcount[AW-1:0] : addr_q;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture) rd_data <= bus_din;
        end
    end

    assign bus_dout = wdata_q;
    assign m1_n     = strobes.m1_n;
    assign mreq_n   = strobes.mreq_n;
    assign iorq_n   = strobes.iorq_n;
    assign rd_n     = strobes.rd_n;
    assign wr_n     = strobes.wr_n;
    assign rfsh_n   = strobes.rfsh_n;
endmodule

// File: rtl/mcyc_strobe_chk.sv
module mcyc_strobe_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          m1_n,
    input logic          mreq_n,
    input logic          iorq_n,
    input logic          rd_n,
    input logic          wr_n,
    input logic          rfsh_n,
    input logic          tri_oe,
    input logic          bus_doe,
    input logic          rd_valid,
    input logic [DW-1:0] bus_dout
);
    AST_ONE_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mreq_n && !iorq_n)); // R6
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n)); // R6
    AST_STROBE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!mreq_n || !iorq_n || !rd_n || !wr_n || !m1_n || !rfsh_n) |-> tri_oe); // R11
    AST_RFSH_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        !rfsh_n |-> (m1_n && rd_n && wr_n && iorq_n)); // R5
    AST_WR_INSIDE_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ((!mreq_n || !iorq_n) && bus_doe)); // R8
    AST_WR_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && $past(!wr_n)) |-> $stable(bus_dout)); // R8
    AST_RDV_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R9
endmodule

bind mcyc_strobe_gen mcyc_strobe_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .m1_n     (m1_n),
    .mreq_n   (mreq_n),
    .iorq_n   (iorq_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .rfsh_n   (rfsh_n),
    .tri_oe   (tri_oe),
    .bus_doe  (bus_doe),
    .rd_valid (rd_valid),
    .bus_dout (bus_dout)
);

// File: tb/tb_mcyc_strobe_gen.sv
module tb_mcyc_strobe_gen;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam time HALF = 2.5ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_type = 3'd7;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_dout;
    logic          bus_doe;
    logic [DW-1:0] bus_din = '0;
    logic          tri_oe, m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n;
    logic [DW-1:0] rd_data;
    logic          rd_valid;

    int errors = 0;
    int checks = 0;
    int rcount = 0;

    always #HALF clk = ~clk;

    mcyc_strobe_gen #(.AW(AW), .DW(DW), .RW(8)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
        .tri_oe(tri_oe), .m1_n(m1_n), .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n),
        .wr_n(wr_n), .rfsh_n(rfsh_n), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One full cycle of kind t; checks every phase against computed expectations.
    task automatic run_cycle(input int t, input int addr, input int wd, input int rv);
        bit rdk, wrk;
        int exp_addr;
        rdk = (t == 0) || (t == 1) || (t == 3) || (t == 5);
        wrk = (t == 2) || (t == 4);
        exp_addr = (t == 6) ? ((addr & 16'hFF00) | (rcount & 8'hFF)) : addr;
        req_valid = 1'b1; req_type = 3'(t); req_addr = AW'(addr); req_wdata = DW'(wd);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_type = 3'd7;
        for (int p = 0; p < 6; p++) begin
            bit mid, late;
            mid  = (p >= 1);
            late = (p >= 2);
            chk("R11", "tri_oe", int'(tri_oe), 1);
            chk("R2", "req_ready", int'(req_ready), (p == 5) ? 1 : 0);
            chk("R7", "bus_addr", int'(bus_addr), exp_addr);
            chk("R3", "m1_n", int'(m1_n), (t == 0 || t == 5) ? 0 : 1);
            chk("R5", "rfsh_n", int'(rfsh_n), (t == 6) ? 0 : 1);
            chk("R6", "mreq_n", int'(mreq_n), (mid && (t <= 2 || t == 6)) ? 0 : 1);
            chk("R4", "iorq_n", int'(iorq_n), (mid && (t >= 3 && t <= 5)) ? 0 : 1);
            chk("R7", "rd_n", int'(rd_n), (mid && (t == 0 || t == 1 || t == 3)) ? 0 : 1);
            chk("R8", "wr_n", int'(wr_n), (late && wrk) ? 0 : 1);
            chk("R8", "bus_doe", int'(bus_doe), (late && wrk) ? 1 : 0);
            if (wrk && late) chk("R8", "bus_dout", int'(bus_dout), wd);
            chk("R9", "rd_valid", int'(rd_valid), (p == 5 && rdk) ? 1 : 0);
            if (p == 5 && rdk) chk("R9", "rd_data", int'(rd_data), rv);
            bus_din = (p == 4) ? DW'(rv) : DW'(~rv);
            @(negedge clk);
        end
        bus_din = '0;
        chk("R2", "tri_oe idle after six clocks", int'(tri_oe), 0);
        chk("R2", "req_ready idle", int'(req_ready), 1);
        if (t == 6) rcount = (rcount + 1) % 256;
    endtask

    initial begin
        #(HALF * 2 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "strobes", int'({m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n}), 6'h3F);
        chk("R1", "tri_oe", int'(tri_oe), 0);
        chk("R1", "bus_doe", int'(bus_doe), 0);
        chk("R1", "rd_valid", int'(rd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "req_ready", int'(req_ready), 1);

        // R5 R1: first refresh shows counter 0
        run_cycle(6, 16'hAB00, 0, 0);

        // sweep kinds 0..6 over several addresses/data
        for (int t = 0; t < 7; t++) begin
            for (int k = 0; k < 4; k++) begin
                run_cycle(t, (k * 16'h4321 + t * 16'h0111) & 16'hFFFF,
                          (k * 37 + t * 11 + 5) & 8'hFF, (k * 53 + t * 29 + 1) & 8'hFF);
            end
        end

        // R12: kind 7 ignored
        req_valid = 1'b1; req_type = 3'd7; req_addr = 16'h1234;
        repeat (3) begin
            @(negedge clk);
            chk("R12", "strobes", int'({m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n}), 6'h3F);
            chk("R12", "tri_oe", int'(tri_oe), 0);
        end
        req_valid = 1'b0;

        // R13: back-to-back fetch then memory read
        req_valid = 1'b1; req_type = 3'd0; req_addr = 16'h0100;
        @(posedge clk);
        repeat (5) @(negedge clk);
        @(negedge clk);
        chk("R13", "T3B ready", int'(req_ready), 1);
        req_type = 3'd1; req_addr = 16'h0200;
        @(negedge clk);
        req_valid = 1'b0; req_type = 3'd7;
        chk("R13", "T1A m1_n", int'(m1_n), 1);
        chk("R13", "T1A mreq_n", int'(mreq_n), 1);
        chk("R13", "T1A tri_oe", int'(tri_oe), 1);
        chk("R13", "T1A addr", int'(bus_addr), 16'h0200);
        @(negedge clk);
        chk("R13", "T1B mreq_n", int'(mreq_n), 0);
        chk("R13", "T1B rd_n", int'(rd_n), 0);
        repeat (5) @(negedge clk);
        chk("R13", "idle after", int'(tri_oe), 0);

        // R10: refresh counter wraps
        for (int i = 0; i < 260; i++) run_cycle(6, ((i * 7) & 8'hFF) << 8, 0, 0);
        chk("R10", "counter wrapped", rcount, (1 + 7 * 4 * 0 + 1 * 4 + 260) % 256);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule